// File: doc/BRIEF.md
# Slew-Limited Voltage-Code Setpoint Sequencer

This block converts a 5-bit voltage-identification code into a digital core-voltage setpoint in millivolts. It does not jump to a new value when the code changes. Instead it walks the setpoint toward the new target one grid step at a time, with one step per programmed interval. The interval is a cycle count that plays the role of an external timing capacitor, so a full-range move can be made to finish inside the required window. The code map has two segments. The upper segment has fine 25 mV steps and the lower segment has coarse 50 mV steps. Two codes in the map mean "no load present" and request that both gate drivers be held low.

The code inputs are asynchronous. They pass through a two-flop synchroniser, and a code must then hold steady for a programmable number of cycles before it counts as valid. This filters out bit skew while the code is changing. While a ramp is running, every new code is held off. Whatever code is stable when the ramp finishes becomes the next target. Moves into or out of an off code, and any move made while the block is disabled, load the setpoint directly with no ramp.

Top module: `vid_slew_seq`

## Requirements
- R1: With code bit 4 set, lower nibble n (0 to 14) gives target 925 + 25·(14 − n) mV, so 11110 is 925 mV and 10000 is 1275 mV.
- R2: With code bit 4 clear, lower nibble n (0 to 14) gives target 1300 + 50·(14 − n) mV, so 01110 is 1300 mV and 00000 is 2000 mV.
- R3: Codes 11111 and 01111 set drv_off high and set both target_mv and setpoint_mv to 0 with no ramp. Leaving an off code loads the new target into the setpoint directly, and busy stays low.
- R4: A code counts only after it has been seen unchanged for STABLE_CYC consecutive cycles past the two-flop synchroniser. A shorter excursion to another code has no effect on target_mv.
- R5: While ramping, the setpoint moves once every step_interval cycles (0 counts as 1) toward the target. The move is 50 mV when the setpoint is at or above 1300 mV and 25 mV otherwise, and the last move is clamped to the target.
- R6: busy rises in the cycle a ramped target is accepted and falls in the same cycle the setpoint reaches the target.
- R7: A code change made while busy is high is not accepted. The code that is stable when busy falls is accepted afterwards.
- R8: With enable low, busy is low, and the setpoint equals the target, which follows the qualified code directly.
- R9: During reset, setpoint_mv and target_mv are 0, busy is low and drv_off is high. The first qualified code after reset is loaded directly.
- R10: target_mv does not change while busy is high and enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Ramping enable; low means direct loading |
| vid_in | input | 5 | Asynchronous voltage-identification code |
| step_interval | input | IV_W | Cycles per ramp step (0 treated as 1) |
| setpoint_mv | output | 12 | Current reference setpoint in mV |
| target_mv | output | 12 | Decoded target in mV |
| busy | output | 1 | Ramp in progress |
| drv_off | output | 1 | Request to hold both gate drivers low |

## Verification
The assertions assume three things. step_interval stays constant for the length of a ramp. enable does not toggle within a single cycle of a code change. Codes that are meant to be accepted stay on vid_in well past the qualification window. The stimulus changes step_interval only while busy is low. It holds every intended code for at least STABLE_CYC plus several cycles. It sweeps every ordered pair of the 32 codes, tracking each ramp cycle by cycle against an arithmetic model of the step rule. Short glitches, mid-ramp code changes and mid-ramp disables are applied on purpose as separate cases.

// File: rtl/vidseq_pkg.sv
package vidseq_pkg;
  localparam int MV_W   = 12;
  localparam int CODE_W = 5;
  typedef logic [MV_W-1:0] mv_t;
  localparam mv_t FINE_BASE   = 12'd925;
  localparam mv_t COARSE_BASE = 12'd1300;
  localparam mv_t FINE_STEP   = 12'd25;
  localparam mv_t COARSE_STEP = 12'd50;
  localparam logic [3:0] TOP_IDX = 4'd14;
endpackage

// File: rtl/vid_sync_filter.sv
module vid_sync_filter #(
  parameter int W          = 5,
  parameter int STABLE_CYC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] code_o,
  output logic         valid_o
);
  localparam int CNT_W = $clog2(STABLE_CYC) + 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(STABLE_CYC - 1);

  logic [W-1:0]     meta_q, sync_q, cand_q;
  logic [CNT_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '1;
      sync_q <= '1;
      cand_q <= '1;
      held_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      if (sync_q != cand_q) begin
        cand_q <= sync_q;
        held_q <= '0;
      end else if (held_q != LIM) begin
        held_q <= held_q + 1'b1;
      end
    end
  end

  assign code_o  = cand_q;
  assign valid_o = (held_q == LIM) && (sync_q == cand_q);

  // R4: a qualified code must have been the candidate on the previous cycle too
  a_r4_valid_held: assert property (@(posedge clk) disable iff (rst)
    (valid_o && (STABLE_CYC > 1)) |-> $stable(cand_q));
endmodule

// File: rtl/vid_decode.sv
module vid_decode
  import vidseq_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output mv_t               mv_o,
  output logic              off_o
);
  logic [3:0] nib;
  logic [3:0] idx;

  always_comb begin
    nib   = code_i[3:0];
    off_o = (nib == 4'hF);
    idx   = TOP_IDX - nib;
    if (off_o)
      mv_o = '0;
    else if (code_i[4])
      mv_o = FINE_BASE + mv_t'(idx) * FINE_STEP;
    else
      mv_o = COARSE_BASE + mv_t'(idx) * COARSE_STEP;
  end
endmodule

// File: rtl/vid_ramp.sv
module vid_ramp
  import vidseq_pkg::*;
#(
  parameter int IV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [CODE_W-1:0] code_i,
  input  mv_t               code_mv,
  input  logic              code_off,
  input  logic              code_ok,
  input  logic [IV_W-1:0]   interval,
  output mv_t               setpoint,
  output mv_t               target,
  output logic              busy,
  output logic              drv_off
);
  logic [CODE_W-1:0] cur_code;
  logic [IV_W-1:0]   timer;
  logic [IV_W-1:0]   lim;
  mv_t               step_sz;
  mv_t               nxt;

  always_comb begin
    lim     = (interval == '0) ? '0 : interval - 1'b1;
    step_sz = (setpoint >= COARSE_BASE) ? COARSE_STEP : FINE_STEP;
    if (target > setpoint)
      nxt = ((target - setpoint) <= step_sz) ? target : setpoint + step_sz;
    else
      nxt = ((setpoint - target) <= step_sz) ? target : setpoint - step_sz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_code <= '1;
      setpoint <= '0;
      target   <= '0;
      busy     <= 1'b0;
      drv_off  <= 1'b1;
      timer    <= '0;
    end else if (!enable) begin
      busy  <= 1'b0;
      timer <= '0;
      if (code_ok) begin
        cur_code <= code_i;
        target   <= code_mv;
        setpoint <= code_mv;
        drv_off  <= code_off;
      end else begin
        setpoint <= target;
      end
    end else if (busy) begin
      if (timer >= lim) begin
        timer    <= '0;
        setpoint <= nxt;
        if (nxt == target) busy <= 1'b0;
      end else begin
        timer <= timer + 1'b1;
      end
    end else if (code_ok && (code_i != cur_code)) begin
      cur_code <= code_i;
      target   <= code_mv;
      drv_off  <= code_off;
      timer    <= '0;
      if (code_off || drv_off)
        setpoint <= code_mv;
      else
        busy <= (code_mv != setpoint);
    end
  end

  a_r10_target_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && enable) |=> $stable(target));

  a_r5_step_bound: assert property (@(posedge clk) disable iff (rst)
    (busy && enable) |=> ((setpoint <= $past(setpoint) + COARSE_STEP) &&
                          (setpoint + COARSE_STEP >= $past(setpoint))));

  a_r5_no_overshoot: assert property (@(posedge clk) disable iff (rst)
    (busy && enable && (target > setpoint)) |=> (setpoint <= target));

  a_r8_disable_idle: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !busy);

  a_r3_off_idle: assert property (@(posedge clk) disable iff (rst)
    drv_off |-> (!busy && (target == '0) && (setpoint == '0)));
endmodule

// File: rtl/vid_slew_seq.sv
module vid_slew_seq
  import vidseq_pkg::*;
#(
  parameter int STABLE_CYC = 4,
  parameter int IV_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [4:0]        vid_in,
  input  logic [IV_W-1:0]   step_interval,
  output logic [MV_W-1:0]   setpoint_mv,
  output logic [MV_W-1:0]   target_mv,
  output logic              busy,
  output logic              drv_off
);
  logic [CODE_W-1:0] q_code;
  logic              q_ok;
  mv_t               q_mv;
  logic              q_off;

  vid_sync_filter #(.W(CODE_W), .STABLE_CYC(STABLE_CYC)) u_sync (
    .clk(clk), .rst(rst), .raw_i(vid_in), .code_o(q_code), .valid_o(q_ok)
  );

  vid_decode u_dec (
    .code_i(q_code), .mv_o(q_mv), .off_o(q_off)
  );

  vid_ramp #(.IV_W(IV_W)) u_ramp (
    .clk(clk), .rst(rst), .enable(enable),
    .code_i(q_code), .code_mv(q_mv), .code_off(q_off), .code_ok(q_ok),
    .interval(step_interval),
    .setpoint(setpoint_mv), .target(target_mv), .busy(busy), .drv_off(drv_off)
  );

  // R9: reset leaves the outputs in the off state on the next cycle
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (drv_off && !busy && (setpoint_mv == '0)));
endmodule

// File: tb/sim_vid_slew_seq.sv
module sim_vid_slew_seq;
  localparam int CLK_PERIOD = 10;
  localparam int STB = 4;
  localparam int IVW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic [4:0] vid_in = 5'b11111;
  logic [IVW-1:0] step_interval = 16'd1;
  logic [11:0] setpoint_mv, target_mv;
  logic busy, drv_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_slew_seq #(.STABLE_CYC(STB), .IV_W(IVW)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .vid_in(vid_in),
    .step_interval(step_interval), .setpoint_mv(setpoint_mv),
    .target_mv(target_mv), .busy(busy), .drv_off(drv_off)
  );

  function automatic bit is_off(input logic [4:0] c);
    return c[3:0] == 4'hF;
  endfunction

  function automatic int dec(input logic [4:0] c);
    if (is_off(c)) return 0;
    if (c[4]) return 925 + 25 * (14 - int'(c[3:0]));
    return 1300 + 50 * (14 - int'(c[3:0]));
  endfunction

  function automatic int nstep(input int sp, input int tg);
    int st;
    st = (sp >= 1300) ? 50 : 25;
    if (tg > sp) return (tg - sp <= st) ? tg : sp + st;
    return (sp - tg <= st) ? tg : sp - st;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 3000 && busy; g++) @(negedge clk);
  endtask

  task automatic go_code(input logic [4:0] c);
    @(negedge clk);
    vid_in = c;
    repeat (STB + 4) @(negedge clk);
    wait_idle();
  endtask

  task automatic wait_busy(output bit seen);
    seen = 0;
    for (int g = 0; g < STB + 10; g++) begin
      @(negedge clk);
      if (busy) begin seen = 1; break; end
    end
  endtask

  // Cycle-by-cycle ramp tracking from the first cycle busy is seen high
  task automatic track(input int start, input int tg, input int iv);
    int model;
    int j;
    model = start;
    j = 0;
    for (int g = 0; g < 5000; g++) begin
      chk(setpoint_mv == model, "R5 setpoint", setpoint_mv, model);
      chk(busy == (model != tg), "R6 busy", busy, model != tg);
      chk(target_mv == tg, "R10 target", target_mv, tg);
      if (model == tg) break;
      @(negedge clk);
      j++;
      if (j % iv == 0) model = nstep(model, tg);
    end
  endtask

  task automatic pair(input logic [4:0] a, input logic [4:0] b, input int iv);
    bit seen;
    go_code(a);
    chk(target_mv == dec(a), a[4] ? "R1 decode" : "R2 decode", target_mv, dec(a));
    chk(setpoint_mv == dec(a), "R3 settle", setpoint_mv, dec(a));
    @(negedge clk);
    vid_in = b;
    if (!is_off(a) && !is_off(b) && a != b) begin
      wait_busy(seen);
      chk(seen, "R6 rise", 0, 1);
      chk(drv_off == 1'b0, "R3 on", drv_off, 0);
      if (seen) track(dec(a), dec(b), iv);
    end else begin
      repeat (STB + 6) begin
        @(negedge clk);
        chk(!busy, "R3 no ramp", busy, 0);
      end
      chk(setpoint_mv == dec(b), "R3 direct", setpoint_mv, dec(b));
      chk(target_mv == dec(b), b[4] ? "R1 target" : "R2 target", target_mv, dec(b));
      chk(drv_off == is_off(b), "R3 drv_off", drv_off, is_off(b));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    // R9 reset state
    vid_in = 5'b10110;
    repeat (3) @(negedge clk);
    chk(setpoint_mv == 0, "R9 setpoint", setpoint_mv, 0);
    chk(target_mv == 0, "R9 target", target_mv, 0);
    chk(!busy, "R9 busy", busy, 0);
    chk(drv_off, "R9 drv_off", drv_off, 1);
    rst = 1'b0;
    repeat (STB + 4) begin
      @(negedge clk);
      chk(!busy, "R9 no ramp", busy, 0);
    end
    chk(setpoint_mv == 1125, "R9 direct load", setpoint_mv, 1125);

    // Full pair sweep with one-cycle interval
    step_interval = 16'd1;
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        pair(5'(a), 5'(b), 1);

    // R5 longer intervals and the zero interval
    step_interval = 16'd3;
    pair(5'b11110, 5'b00000, 3);
    pair(5'b00000, 5'b10011, 3);
    step_interval = 16'd0;
    pair(5'b10111, 5'b01010, 1);

    // R4 short glitch is filtered
    step_interval = 16'd2;
    go_code(5'b11000);
    @(negedge clk); vid_in = 5'b00001;
    repeat (2) @(negedge clk); vid_in = 5'b11000;
    repeat (STB + 8) begin
      @(negedge clk);
      chk(target_mv == 1075, "R4 glitch", target_mv, 1075);
      chk(!busy, "R4 glitch busy", busy, 0);
    end

    // R7 lockout during a ramp
    step_interval = 16'd4;
    go_code(5'b11110);
    @(negedge clk); vid_in = 5'b00000;
    wait_busy(seen);
    chk(seen, "R7 first ramp", 0, 1);
    repeat (20) @(negedge clk);
    vid_in = 5'b10000;
    for (int g = 0; g < 400 && busy; g++) begin
      chk(target_mv == 2000, "R7 held target", target_mv, 2000);
      @(negedge clk);
    end
    chk(setpoint_mv == 2000, "R7 first done", setpoint_mv, 2000);
    wait_busy(seen);
    chk(seen, "R7 second ramp", 0, 1);
    chk(target_mv == 1275, "R7 next target", target_mv, 1275);
    wait_idle();
    chk(setpoint_mv == 1275, "R7 second done", setpoint_mv, 1275);

    // R8 disable mid-ramp and direct follow
    go_code(5'b11110);
    @(negedge clk); vid_in = 5'b00000;
    wait_busy(seen);
    repeat (10) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!busy, "R8 busy drop", busy, 0);
    chk(setpoint_mv == 2000, "R8 jump", setpoint_mv, 2000);
    vid_in = 5'b10000;
    repeat (STB + 4) begin
      @(negedge clk);
      chk(!busy, "R8 stays idle", busy, 0);
    end
    chk(setpoint_mv == 1275, "R8 follow", setpoint_mv, 1275);
    chk(target_mv == 1275, "R8 target", target_mv, 1275);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy, "R8 re-enable", busy, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule